// File: doc/BRIEF.md
# Shared Interrupt Distributor with Per-CPU Routing

This block collects interrupt lines from peripherals and from each processor's private sources. It decides, for every interrupt ID, whether the ID is allowed through, whether it is waiting, and which processor interfaces should see it. Software programs it through a 32-bit register port. Each access on that port carries the number of the requesting processor. The block drives one request vector per processor interface. Bit `c*NUM_IRQ + n` of `irq_o` means that ID `n` is asking processor `c` for service.

IDs 0 to 31 are private to each processor. Every processor has its own copy of their enable bits, trigger configuration and pending latches. Each processor reaches only its own copy, through the same addresses. IDs 32 and up are shared by all processors. Each shared ID has one enable bit, one trigger bit and one routing byte. Each bit of the routing byte selects one processor interface.

Software clears the global enable, rewrites the configuration, and then sets the enable again. A level source is pending for as long as its line is high. An edge source is latched on a rising edge seen while the block is enabled, and stays pending until an acknowledge names it.

The register port is a valid/ready request channel with a valid/ready response channel for reads:
- A request is taken on a cycle where `req_valid_i` and `req_ready_o` are both high.
- A write takes effect at that edge and gives no response.
- A read places its data on `rsp_rdata_o` with `rsp_valid_o` one cycle later.
- The read data stays there until a cycle where `rsp_ready_i` is high.
- While a read response waits, `req_ready_o` stays low, so no further request is accepted.

Top module: `idist_top`

## Requirements
- R1: After reset the control word is 0 and all enables are 0. All routing bytes of shared IDs are 0, all shared IDs are level-triggered, no edge is latched, `irq_o` is all zero and no response is valid.
- R2: Bit 0 of the control word at byte address 0x000 is the global enable. `irq_o` is all zero from the cycle after a write clears it. While it is clear, no request is forwarded, whatever the enables and lines are.
- R3: Writing the set-enable word at 0x100+4k sets the enable of ID 32k+b for every data bit b that is 1. Bits written as 0 leave their enable unchanged.
- R4: Writing the clear-enable word at 0x180+4k clears the enable of ID 32k+b for every data bit b that is 1, and bits written as 0 have no effect. Reads of either word return the current enable bits.
- R5: The routing word at 0x400+4k holds the routing bytes of IDs 4k to 4k+3, and ID 4k+b uses bits 8b to 8b+7. For a shared ID, bit c of its byte routes it to processor c. Routing bits at or above NUM_CPU read as 0. A shared ID requests only the processors whose routing bit is set.
- R6: Enable, pending and trigger state of IDs 0 to 31 are kept per processor, and an access reaches the copy of the requesting processor. Routing words 0 to 7 read, in every byte, a value with only bit `req_cpu_i` set. Writes to those words are ignored.
- R7: The configuration word at 0x800+4k holds the 2-bit fields of IDs 16k to 16k+15. ID n uses bits 2(n mod 16)+1 and 2(n mod 16). Field 00 means level-high and 10 means rising edge. The low bit of each field is ignored and reads 0. IDs 0 to 15 always read 10 and ignore writes.
- R8: The read-only word at 0x004 returns NUM_IRQ/32-1 in bits 4:0 and 0 elsewhere. Writes to it are ignored.
- R9: A level-configured ID is pending while its line is high. If enabled and routed, it shows on `irq_o` one cycle after the line rises. A level line still high when the global enable is set again requests again.
- R10: An edge-configured ID latches a rising edge seen while the global enable is set. A rising edge seen while the global enable is clear is not latched. The latch holds after the line falls, until an acknowledge with `ack_cpu_i` and `ack_id_i` naming the ID clears it. Pending state of ID 32k+b reads at bit b of 0x200+4k.
- R11: A request is taken when `req_valid_i` and `req_ready_o` are both high. Read data appears with `rsp_valid_o` one cycle later and stays stable until `rsp_ready_i` is high. `req_ready_o` is low only while a response waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cpu_i | input | CPU_W | Number of the requesting processor |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response taken |
| rsp_rdata_o | output | 32 | Read data |
| local_irq_i | input | NUM_CPU*32 | Private lines, bit c*32+n is ID n of processor c |
| spi_irq_i | input | NUM_IRQ-32 | Shared lines, bit i is ID 32+i |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_cpu_i | input | CPU_W | Processor giving the acknowledge |
| ack_id_i | input | ID_W | ID being acknowledged |
| irq_o | output | NUM_CPU*NUM_IRQ | Request, bit c*NUM_IRQ+n is ID n towards processor c |

## Verification
Shared lines are driven in three ways, and each separates one kind of fault:
- Several shared lines are held high at once with different routing bytes. This shows whether routing picks the right processors and no others.
- The same held lines are gated by toggling the global enable. A level source must return after re-enable, which separates level behaviour from edge behaviour.
- A one-cycle pulse is given to an edge-configured ID, once with the global enable set and once with it clear. The first must latch and hold until acknowledged; the second must leave nothing pending.

Private lines are raised on two processors at the same time, with the enable set for only one of them, which exposes any sharing between the banked copies. A read is held unanswered for several cycles to check that back-pressure stalls the request channel.

// File: rtl/idist_pkg.sv
package idist_pkg;

  // Register regions of the distributor
  typedef enum logic [2:0] {
    RG_NONE,
    RG_CTRL,
    RG_TYPE,
    RG_ENSET,
    RG_ENCLR,
    RG_PEND,
    RG_TGT,
    RG_CFG
  } idist_rg_e;

  // Word (address >> 2) base of each region
  localparam logic [9:0] WB_CTRL  = 10'h000;
  localparam logic [9:0] WB_TYPE  = 10'h001;
  localparam logic [9:0] WB_ENSET = 10'h040;
  localparam logic [9:0] WB_ENCLR = 10'h060;
  localparam logic [9:0] WB_PEND  = 10'h080;
  localparam logic [9:0] WB_TGT   = 10'h100;
  localparam logic [9:0] WB_CFG   = 10'h200;

  localparam int LOCAL_IDS = 32;
  localparam int FIXED_IDS = 16;

  // Decoded write strobe handed to the state holders
  typedef struct packed {
    logic        wr;
    idist_rg_e   rg;
    logic [9:0]  idx;
    logic [31:0] data;
  } idist_wr_t;

endpackage

// File: rtl/idist_capture.sv
module idist_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] clr_i,
  input  logic         gate_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] latch_q;
  logic [N-1:0] rise;

  // A rise counts only while forwarding is globally on
  assign rise = line_i & ~prev_q & edge_i & {N{gate_i}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= line_i;
      latch_q <= (latch_q & ~clr_i) | rise;
    end
  end

  // Edge IDs show the latch, level IDs follow the live line
  assign pend_o = (edge_i & latch_q) | (~edge_i & line_i);

endmodule

// File: rtl/idist_local.sv
module idist_local
  import idist_pkg::*;
#(
  parameter int MY_CPU = 0,
  parameter int CPU_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  idist_wr_t        wr_i,
  input  logic [CPU_W-1:0] wr_cpu_i,
  input  logic [31:0]      line_i,
  input  logic             gate_i,
  input  logic [31:0]      clr_i,
  output logic [31:0]      en_o,
  output logic [31:0]      edge_o,
  output logic [31:0]      pend_o
);

  localparam int CFG_N = LOCAL_IDS - FIXED_IDS;

  logic [31:0]      en_q;
  logic [CFG_N-1:0] cfg_q;
  logic             mine;

  assign mine = wr_i.wr && (wr_cpu_i == CPU_W'(MY_CPU));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else if (mine) begin
      case (wr_i.rg)
        RG_ENSET: if (wr_i.idx == 10'd0) en_q <= en_q | wr_i.data;
        RG_ENCLR: if (wr_i.idx == 10'd0) en_q <= en_q & ~wr_i.data;
        RG_CFG: begin
          if (wr_i.idx == 10'd1) begin
            for (int j = 0; j < CFG_N; j++) cfg_q[j] <= wr_i.data[2*j+1];
          end
        end
        default: ;
      endcase
    end
  end

  // IDs below FIXED_IDS are always edge
  assign edge_o = {cfg_q, {FIXED_IDS{1'b1}}};
  assign en_o   = en_q;

  idist_capture #(.N(32)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .edge_i (edge_o),
    .clr_i  (clr_i),
    .gate_i (gate_i),
    .pend_o (pend_o)
  );

endmodule

// File: rtl/idist_shared.sv
module idist_shared
  import idist_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  idist_wr_t                      wr_i,
  input  logic [NUM_IRQ-33:0]            line_i,
  input  logic                           gate_i,
  input  logic [NUM_IRQ-33:0]            clr_i,
  output logic [NUM_IRQ-33:0]            en_o,
  output logic [NUM_IRQ-33:0]            edge_o,
  output logic [NUM_IRQ-33:0][NUM_CPU-1:0] tgt_o,
  output logic [NUM_IRQ-33:0]            pend_o
);

  localparam int NSPI = NUM_IRQ - LOCAL_IDS;

  logic [NSPI-1:0]              en_q;
  logic [NSPI-1:0]              edge_q;
  logic [NSPI-1:0][NUM_CPU-1:0] tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      edge_q <= '0;
      tgt_q  <= '0;
    end else if (wr_i.wr) begin
      for (int i = 0; i < NSPI; i++) begin
        case (wr_i.rg)
          RG_ENSET:
            if (int'(wr_i.idx) == (i + LOCAL_IDS) / 32 && wr_i.data[(i + LOCAL_IDS) % 32])
              en_q[i] <= 1'b1;
          RG_ENCLR:
            if (int'(wr_i.idx) == (i + LOCAL_IDS) / 32 && wr_i.data[(i + LOCAL_IDS) % 32])
              en_q[i] <= 1'b0;
          RG_TGT:
            if (int'(wr_i.idx) == (i + LOCAL_IDS) / 4)
              tgt_q[i] <= wr_i.data[8*((i + LOCAL_IDS) % 4) +: NUM_CPU];
          RG_CFG:
            if (int'(wr_i.idx) == (i + LOCAL_IDS) / 16)
              edge_q[i] <= wr_i.data[2*((i + LOCAL_IDS) % 16) + 1];
          default: ;
        endcase
      end
    end
  end

  assign en_o   = en_q;
  assign edge_o = edge_q;
  assign tgt_o  = tgt_q;

  idist_capture #(.N(NSPI)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .edge_i (edge_q),
    .clr_i  (clr_i),
    .gate_i (gate_i),
    .pend_o (pend_o)
  );

endmodule

// File: rtl/idist_top.sv
module idist_top
  import idist_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int ID_W   = $clog2(NUM_IRQ)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic                       req_write_i,
  input  logic [CPU_W-1:0]           req_cpu_i,
  input  logic [11:0]                req_addr_i,
  input  logic [31:0]                req_wdata_i,
  output logic                       rsp_valid_o,
  input  logic                       rsp_ready_i,
  output logic [31:0]                rsp_rdata_o,
  input  logic [NUM_CPU*32-1:0]      local_irq_i,
  input  logic [NUM_IRQ-33:0]        spi_irq_i,
  input  logic                       ack_valid_i,
  input  logic [CPU_W-1:0]           ack_cpu_i,
  input  logic [ID_W-1:0]            ack_id_i,
  output logic [NUM_CPU*NUM_IRQ-1:0] irq_o
);

  localparam int NSPI = NUM_IRQ - LOCAL_IDS;
  localparam int NW32 = NUM_IRQ / 32;
  localparam int NW4  = NUM_IRQ / 4;
  localparam int NW16 = NUM_IRQ / 16;
  localparam logic [4:0] TYPE_FIELD = 5'(NW32 - 1);

  // ---------------- decode ----------------
  logic [9:0] word;
  idist_rg_e  rg;
  logic [9:0] idx;
  logic       accept;
  idist_wr_t  wr;
  logic       unused_addr;

  assign word        = req_addr_i[11:2];
  assign unused_addr = ^req_addr_i[1:0];

  always_comb begin
    rg  = RG_NONE;
    idx = '0;
    if (word == WB_CTRL) begin
      rg = RG_CTRL;
    end else if (word == WB_TYPE) begin
      rg = RG_TYPE;
    end else if (word >= WB_ENSET && word < WB_ENSET + 10'(NW32)) begin
      rg = RG_ENSET; idx = word - WB_ENSET;
    end else if (word >= WB_ENCLR && word < WB_ENCLR + 10'(NW32)) begin
      rg = RG_ENCLR; idx = word - WB_ENCLR;
    end else if (word >= WB_PEND && word < WB_PEND + 10'(NW32)) begin
      rg = RG_PEND; idx = word - WB_PEND;
    end else if (word >= WB_TGT && word < WB_TGT + 10'(NW4)) begin
      rg = RG_TGT; idx = word - WB_TGT;
    end else if (word >= WB_CFG && word < WB_CFG + 10'(NW16)) begin
      rg = RG_CFG; idx = word - WB_CFG;
    end
  end

  logic rsp_valid_q;
  logic [31:0] rsp_data_q;

  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  assign wr.wr   = accept && req_write_i;
  assign wr.rg   = rg;
  assign wr.idx  = idx;
  assign wr.data = req_wdata_i;

  // ---------------- global enable ----------------
  logic ctrl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 1'b0;
    else if (wr.wr && rg == RG_CTRL) ctrl_q <= req_wdata_i[0];
  end

  // ---------------- banked private state ----------------
  logic [NUM_CPU-1:0][31:0] loc_en, loc_edge, loc_pend, loc_clr;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign loc_clr[c] = (ack_valid_i && ack_cpu_i == CPU_W'(c) && ack_id_i < ID_W'(LOCAL_IDS))
                        ? (32'h1 << ack_id_i[4:0]) : 32'h0;

    idist_local #(.MY_CPU(c), .CPU_W(CPU_W)) u_loc (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr),
      .wr_cpu_i (req_cpu_i),
      .line_i   (local_irq_i[c*32 +: 32]),
      .gate_i   (ctrl_q),
      .clr_i    (loc_clr[c]),
      .en_o     (loc_en[c]),
      .edge_o   (loc_edge[c]),
      .pend_o   (loc_pend[c])
    );
  end

  // ---------------- shared state ----------------
  logic [NSPI-1:0]              spi_en, spi_edge, spi_pend, spi_clr;
  logic [NSPI-1:0][NUM_CPU-1:0] spi_tgt;
  logic                         unused_spi_edge;

  assign spi_clr = (ack_valid_i && ack_id_i >= ID_W'(LOCAL_IDS))
                   ? (NSPI'(1) << (ack_id_i - ID_W'(LOCAL_IDS))) : '0;
  assign unused_spi_edge = ^spi_edge;

  idist_shared #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_spi (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr),
    .line_i (spi_irq_i),
    .gate_i (ctrl_q),
    .clr_i  (spi_clr),
    .en_o   (spi_en),
    .edge_o (spi_edge),
    .tgt_o  (spi_tgt),
    .pend_o (spi_pend)
  );

  // ---------------- read mux ----------------
  logic [31:0] rd_data;
  logic [31:0] sel_en, sel_edge, sel_pend;
  logic [7:0]  own_byte;

  assign own_byte = 8'h01 << req_cpu_i;

  always_comb begin
    sel_en = '0; sel_edge = '0; sel_pend = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (req_cpu_i == CPU_W'(c)) begin
        sel_en = loc_en[c]; sel_edge = loc_edge[c]; sel_pend = loc_pend[c];
      end
    end
    rd_data = '0;
    case (rg)
      RG_CTRL: rd_data[0] = ctrl_q;
      RG_TYPE: rd_data[4:0] = TYPE_FIELD;
      RG_ENSET, RG_ENCLR: begin
        if (idx == 10'd0) rd_data = sel_en;
        else for (int i = 0; i < NSPI; i++)
          if (int'(idx) == (i + LOCAL_IDS) / 32) rd_data[(i + LOCAL_IDS) % 32] = spi_en[i];
      end
      RG_PEND: begin
        if (idx == 10'd0) rd_data = sel_pend;
        else for (int i = 0; i < NSPI; i++)
          if (int'(idx) == (i + LOCAL_IDS) / 32) rd_data[(i + LOCAL_IDS) % 32] = spi_pend[i];
      end
      RG_TGT: begin
        if (idx < 10'd8) rd_data = {4{own_byte}};
        else for (int i = 0; i < NSPI; i++)
          if (int'(idx) == (i + LOCAL_IDS) / 4)
            rd_data[8*((i + LOCAL_IDS) % 4) +: NUM_CPU] = spi_tgt[i];
      end
      RG_CFG: begin
        if (idx == 10'd0) rd_data = 32'hAAAA_AAAA;
        else if (idx == 10'd1) begin
          for (int j = 0; j < LOCAL_IDS - FIXED_IDS; j++) rd_data[2*j+1] = sel_edge[FIXED_IDS+j];
        end else for (int i = 0; i < NSPI; i++)
          if (int'(idx) == (i + LOCAL_IDS) / 16) rd_data[2*((i + LOCAL_IDS) % 16) + 1] = spi_edge[i];
      end
      default: rd_data = '0;
    endcase
  end

  // ---------------- response channel ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept && !req_write_i) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_data;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  // ---------------- request forming ----------------
  logic [NUM_CPU*NUM_IRQ-1:0] irq_d, irq_q;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int n = 0; n < LOCAL_IDS; n++)
        irq_d[c*NUM_IRQ + n] = ctrl_q & loc_en[c][n] & loc_pend[c][n];
      for (int i = 0; i < NSPI; i++)
        irq_d[c*NUM_IRQ + LOCAL_IDS + i] = ctrl_q & spi_en[i] & spi_pend[i] & spi_tgt[i][c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/idist_chk.sv
module idist_chk #(
  parameter int W = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctrl_q,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_write,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [31:0]  rsp_rdata,
  input logic [W-1:0] irq
);

  // R1: reset leaves no request and no response
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq == '0) && !rsp_valid);

  // R2: global enable off silences every output on the next cycle
  a_r2_off_silences: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q |=> (irq == '0));

  // R11: a waiting response holds its data
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R11: ready drops only while a response is waiting
  a_r11_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> rsp_valid);

  // R11: a new response follows an accepted read
  a_r11_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));

endmodule

bind idist_top idist_chk #(.W(NUM_CPU*NUM_IRQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_q    (ctrl_q),
  .req_valid (req_valid_i),
  .req_ready (req_ready_o),
  .req_write (req_write_i),
  .rsp_valid (rsp_valid_o),
  .rsp_ready (rsp_ready_i),
  .rsp_rdata (rsp_rdata_o),
  .irq       (irq_o)
);

// File: tb/idist_top_tb.sv
module idist_top_tb;

  localparam int NC = 4;
  localparam int NI = 64;
  localparam int NS = NI - 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [1:0]        req_cpu = '0;
  logic [11:0]       req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [31:0]       rsp_rdata;
  logic [NC*32-1:0]  local_irq = '0;
  logic [NS-1:0]     spi_irq = '0;
  logic              ack_valid = 1'b0;
  logic [1:0]        ack_cpu = '0;
  logic [5:0]        ack_id = '0;
  logic [NC*NI-1:0]  irq;

  idist_top #(.NUM_CPU(NC), .NUM_IRQ(NI)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_cpu_i(req_cpu), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .local_irq_i(local_irq), .spi_irq_i(spi_irq),
    .ack_valid_i(ack_valid), .ack_cpu_i(ack_cpu), .ack_id_i(ack_id),
    .irq_o(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rsp_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_cpu = 2'(cpu); req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_cpu = 2'(cpu); req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic ack(input int cpu, input int id);
    @(negedge clk);
    ack_valid = 1'b1; ack_cpu = 2'(cpu); ack_id = 6'(id);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  function automatic logic [31:0] ib(input int cpu, input int id);
    return {31'b0, irq[cpu*NI + id]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 irq_o zero", {31'b0, |irq}, 32'h0);
    rd(0, 12'h000, 32'h0, "R1 control");
    rd(0, 12'h104, 32'h0, "R1 enables");
    rd(0, 12'h420, 32'h0, "R1 routing");
    rd(0, 12'h808, 32'h0, "R1 config");
    rd(0, 12'h204, 32'h0, "R1 pending");

    // R8 type word
    rd(0, 12'h004, 32'h1, "R8 type");
    wr(0, 12'h004, 32'h1F);
    rd(0, 12'h004, 32'h1, "R8 type after write");

    // R3 / R4 set and clear
    wr(0, 12'h104, 32'h5);
    wr(0, 12'h104, 32'h0);
    rd(0, 12'h104, 32'h5, "R3 set-enable read");
    rd(0, 12'h184, 32'h5, "R4 clear-enable read");
    wr(0, 12'h184, 32'h1);
    rd(0, 12'h104, 32'h4, "R4 after clear");
    wr(0, 12'h184, 32'h0);
    rd(0, 12'h184, 32'h4, "R4 zero write no effect");
    wr(0, 12'h104, 32'h1);

    // R5 routing
    wr(0, 12'h420, 32'h0004_00F3);
    rd(0, 12'h420, 32'h0004_0003, "R5 routing read");
    wr(0, 12'h000, 32'h1);
    spi_irq[0] = 1'b1;
    spi_irq[2] = 1'b1;
    idle(2);
    chk("R9 level id34 cpu2", ib(2, 34), 32'h1);
    chk("R5 id34 not cpu0", ib(0, 34), 32'h0);
    chk("R5 id32 cpu0", ib(0, 32), 32'h1);
    chk("R5 id32 cpu1", ib(1, 32), 32'h1);
    chk("R5 id32 not cpu2", ib(2, 32), 32'h0);

    // R2 global enable
    wr(0, 12'h000, 32'h0);
    idle(2);
    chk("R2 all quiet when off", {31'b0, |irq}, 32'h0);
    wr(0, 12'h000, 32'h1);
    idle(2);
    chk("R9 level back after re-enable", ib(2, 34), 32'h1);

    // R7 / R10 edge on id33
    wr(0, 12'h808, 32'hC);
    rd(0, 12'h808, 32'h8, "R7 low field bit ignored");
    wr(0, 12'h104, 32'h2);
    wr(0, 12'h420, 32'h0004_08F3);
    @(negedge clk); spi_irq[1] = 1'b1;
    @(negedge clk); spi_irq[1] = 1'b0;
    idle(1);
    chk("R10 edge latched", ib(3, 33), 32'h1);
    rd(0, 12'h204, 32'h7, "R10 pending word");
    idle(2);
    chk("R10 latch holds after fall", ib(3, 33), 32'h1);
    ack(3, 33);
    idle(1);
    chk("R10 ack clears", ib(3, 33), 32'h0);
    rd(0, 12'h204, 32'h5, "R10 pending after ack");
    wr(0, 12'h000, 32'h0);
    @(negedge clk); spi_irq[1] = 1'b1;
    @(negedge clk); spi_irq[1] = 1'b0;
    wr(0, 12'h000, 32'h1);
    idle(2);
    chk("R10 edge while off not latched", ib(3, 33), 32'h0);
    rd(0, 12'h204, 32'h5, "R10 pending after off edge");

    // R6 banked private IDs
    wr(1, 12'h100, 32'h0010_0000);
    local_irq[1*32 + 20] = 1'b1;
    local_irq[0*32 + 20] = 1'b1;
    idle(2);
    chk("R6 cpu1 id20", ib(1, 20), 32'h1);
    chk("R6 cpu0 id20 not enabled", ib(0, 20), 32'h0);
    rd(0, 12'h100, 32'h0, "R6 cpu0 enable copy");
    rd(1, 12'h100, 32'h0010_0000, "R6 cpu1 enable copy");
    rd(2, 12'h200, 32'h0, "R6 cpu2 pending copy");
    rd(2, 12'h400, 32'h0404_0404, "R6 private routing cpu2");
    wr(2, 12'h400, 32'hFFFF_FFFF);
    rd(2, 12'h400, 32'h0404_0404, "R6 private routing write ignored");
    rd(0, 12'h41C, 32'h0101_0101, "R6 private routing cpu0");

    // R7 configuration banking
    rd(0, 12'h800, 32'hAAAA_AAAA, "R7 fixed edge IDs");
    wr(0, 12'h800, 32'h0);
    rd(0, 12'h800, 32'hAAAA_AAAA, "R7 fixed write ignored");
    wr(1, 12'h804, 32'h200);
    rd(1, 12'h804, 32'h200, "R7 cpu1 config");
    rd(0, 12'h804, 32'h0, "R7 cpu0 config untouched");
    idle(2);
    chk("R7 held line no edge after switch", ib(1, 20), 32'h0);
    @(negedge clk); local_irq[1*32 + 20] = 1'b0;
    @(negedge clk); local_irq[1*32 + 20] = 1'b1;
    @(negedge clk); local_irq[1*32 + 20] = 1'b0;
    idle(1);
    chk("R10 private edge latched", ib(1, 20), 32'h1);
    ack(1, 20);
    idle(1);
    chk("R10 private ack clears", ib(1, 20), 32'h0);

    // R11 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    rd(0, 12'h000, 32'h1, "R11 stalled read data");
    idle(1);
    chk("R11 ready low while waiting", {31'b0, req_ready}, 32'h0);
    chk("R11 response valid", {31'b0, rsp_valid}, 32'h1);
    idle(2);
    chk("R11 data stable", rsp_rdata, 32'h1);
    @(posedge clk); #1 rsp_ready = 1'b1;
    idle(4);
    chk("R11 all responses seen", 32'(exp_q.size()), 32'h0);

    summary();
    $finish;
  end

endmodule